// File: doc/BRIEF.md
# 4B/5B Serial Byte Transmitter with NRZI Line Coding

This block turns a stream of parallel bytes into a single-wire serial line signal. The producer offers a byte together with a strobe. The block takes the byte only in the one cycle of every code word in which it raises its ready output. An accepted byte is held in a holding register, so the producer may change its data on the next cycle. In the following word slot, each nibble of the held byte becomes a 5-bit data symbol. The two symbols go out one bit per clock, and every code bit is converted to a line level by NRZI. When no byte is waiting, the block fills the word slot with a fixed sync symbol pair, so the line never goes quiet.

The clock is the line bit clock. One word takes ten clocks and carries eight data bits, so the line runs at 5/4 of the data rate. The reset input is asynchronous and active low. It is released inside the block through a two-stage synchronizer.

Top module: `sym45_line_tx`

## Requirements
- R1: While reset is applied, `line_out` and `tx_ready` are low. After release, the first 10-bit word sent is the sync pair 11000 10001, and the line starts from a low level.
- R2: Once running, `tx_ready` is high for exactly one cycle in every 10 cycles. This is the last bit cycle of the word on the line.
- R3: A byte on `tx_data` with `tx_strobe` high during a `tx_ready` cycle is accepted. It is sent in the word that starts one full word (10 cycles) after the word starting at that ready cycle's next edge. Data changes after acceptance have no effect on it.
- R4: Each nibble is coded with this map (hex nibble to 5-bit symbol):
  - 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111
  - 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101
- R5: Within a word, the high nibble's symbol is sent before the low nibble's symbol, and each symbol is sent most significant bit first.
- R6: The code bit sent in a cycle sets the line level in the next cycle: a 1 inverts `line_out`, and a 0 keeps it.
- R7: If no byte was accepted at the previous ready cycle, the next word is the sync pair 11000 followed by 10001.
- R8: `tx_strobe` and `tx_data` are ignored in every cycle where `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte offered by the producer |
| tx_strobe | input | 1 | Producer has a byte on tx_data |
| tx_ready | output | 1 | Word boundary; byte taken if strobed |
| line_out | output | 1 | NRZI serial line level |

## Verification
Faults show up on the line level, because every code bit decides whether `line_out` toggles one cycle later:
- A wrong shift register bit gives a missing or extra transition in the very next cycle.
- A wrong bit counter moves `tx_ready` away from its ten-cycle cadence within one word.
- A holding register that takes data outside the ready cycle, or drops a byte, only shows at the line one word later. It then shows as a data word where sync was due, or the reverse.

The bench decodes the line against a model built from the requirements, cycle by cycle.

// File: rtl/sym45_pkg.sv
package sym45_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;
  localparam logic [SYM_W-1:0] SYM_J = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K = 5'b10001;

  function automatic logic [SYM_W-1:0] nib_to_sym(input logic [NIB_W-1:0] nib);
    logic [SYM_W-1:0] s;
    case (nib)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sym45_rst_sync.sv
module sym45_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sym45_byte_hold.sv
module sym45_byte_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q
);
  logic              valid_d;
  logic [DATA_W-1:0] data_d;
  logic              valid_en;
  logic              data_en;

  always_comb begin
    valid_en = take;
    data_en  = take & strobe;
    valid_d  = strobe;
    data_d   = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (valid_en) valid_q <= valid_d;
      if (data_en)  data_q  <= data_d;
    end
  end
endmodule

// File: rtl/sym45_encoder.sv
module sym45_encoder
  import sym45_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 10
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic [WORD_W-1:0] data_word_o,
  output logic [WORD_W-1:0] sync_word_o
);
  localparam int NSYM = DATA_W / NIB_W;

  for (genvar s = 0; s < NSYM; s++) begin : g_sym
    assign data_word_o[s*SYM_W +: SYM_W] = nib_to_sym(byte_i[s*NIB_W +: NIB_W]);
    if (((NSYM - 1 - s) % 2) == 0) begin : g_first
      assign sync_word_o[s*SYM_W +: SYM_W] = SYM_J;
    end else begin : g_second
      assign sync_word_o[s*SYM_W +: SYM_W] = SYM_K;
    end
  end
endmodule

// File: rtl/sym45_shifter.sv
module sym45_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] load_word,
  output logic              at_last,
  output logic              code_bit,
  output logic [WORD_W-1:0] word_q
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int LAST  = WORD_W - 1;

  logic [WORD_W-1:0] sreg_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;

  assign at_last  = (cnt_q == CNT_W'(LAST));
  assign code_bit = word_q[WORD_W-1];

  always_comb begin
    if (at_last) begin
      sreg_d = load_word;
      cnt_d  = '0;
    end else begin
      sreg_d = {word_q[WORD_W-2:0], 1'b0};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= CNT_W'(LAST);
    end else begin
      word_q <= sreg_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sym45_nrzi.sv
module sym45_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic code_bit,
  output logic line_q
);
  logic line_d;

  always_comb begin
    line_d = line_q ^ code_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/sym45_line_tx.sv
module sym45_line_tx #(
  parameter int DATA_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_strobe,
  output logic              tx_ready,
  output logic              line_out
);
  localparam int NSYM   = DATA_W / sym45_pkg::NIB_W;
  localparam int WORD_W = NSYM * sym45_pkg::SYM_W;

  logic              run_n;
  logic              at_last;
  logic              code_bit;
  logic              hold_v;
  logic [DATA_W-1:0] hold_b;
  logic [WORD_W-1:0] data_word;
  logic [WORD_W-1:0] sync_word;
  logic [WORD_W-1:0] load_word;
  logic [WORD_W-1:0] cur_word;

  sym45_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(run_n)
  );

  assign tx_ready  = at_last & run_n;
  assign load_word = hold_v ? data_word : sync_word;

  sym45_byte_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(run_n), .take(tx_ready), .strobe(tx_strobe),
    .data_i(tx_data), .valid_q(hold_v), .data_q(hold_b)
  );

  sym45_encoder #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_enc (
    .byte_i(hold_b), .data_word_o(data_word), .sync_word_o(sync_word)
  );

  sym45_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(run_n), .load_word(load_word),
    .at_last(at_last), .code_bit(code_bit), .word_q(cur_word)
  );

  sym45_nrzi u_nrzi (
    .clk(clk), .rst_n(run_n), .code_bit(code_bit), .line_q(line_out)
  );
endmodule

// File: rtl/sym45_checks.sv
module sym45_checks
  import sym45_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              run_n,
  input logic              tx_ready,
  input logic              tx_strobe,
  input logic [DATA_W-1:0] tx_data,
  input logic              line_out,
  input logic              code_bit,
  input logic              hold_v,
  input logic [DATA_W-1:0] hold_b,
  input logic [WORD_W-1:0] cur_word
);
  localparam int NSYM = DATA_W / NIB_W;

  logic [WORD_W-1:0] exp_sync;
  for (genvar s = 0; s < NSYM; s++) begin : g_es
    assign exp_sync[WORD_W-1-s*SYM_W -: SYM_W] = ((s % 2) == 0) ? SYM_J : SYM_K;
  end

  logic [15:0] gap_q;
  logic        seen_q;
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tx_ready) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q  <= gap_q + 16'd1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !run_n |-> (!line_out && !tx_ready));

  p_ready_single_r2: assert property (@(posedge clk) disable iff (!run_n)
    tx_ready |=> !tx_ready);

  p_ready_period_r2: assert property (@(posedge clk) disable iff (!run_n)
    tx_ready |-> (!seen_q || gap_q == 16'(WORD_W - 1)));

  p_accept_r3: assert property (@(posedge clk) disable iff (!run_n)
    (tx_ready && tx_strobe) |=> (hold_v && hold_b == $past(tx_data)));

  p_nrzi_r6: assert property (@(posedge clk) disable iff (!run_n)
    1'b1 |=> ((line_out ^ $past(line_out)) == $past(code_bit)));

  p_sync_fill_r7: assert property (@(posedge clk) disable iff (!run_n)
    (tx_ready && !hold_v) |=> (cur_word == exp_sync));

  p_ignore_idle_r8: assert property (@(posedge clk) disable iff (!run_n)
    !tx_ready |=> ($stable(hold_v) && $stable(hold_b)));
endmodule

bind sym45_line_tx sym45_checks #(.DATA_W(DATA_W), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .run_n(run_n), .tx_ready(tx_ready), .tx_strobe(tx_strobe),
  .tx_data(tx_data), .line_out(line_out), .code_bit(code_bit),
  .hold_v(hold_v), .hold_b(hold_b), .cur_word(cur_word)
);

// File: tb/sym45_line_tx_tb_top.sv
module sym45_line_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_strobe = 1'b0;
  logic       tx_ready;
  logic       line_out;

  always #10 clk = ~clk;

  sym45_line_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_strobe(tx_strobe),
    .tx_ready(tx_ready), .line_out(line_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  bit         started;
  int         mc;
  logic [9:0] mw;
  bit         mhv;
  logic [7:0] mhb;
  logic       exp_line;
  int         mkind, prev_kind;
  int         wait_cyc;
  int         mode;
  int         dir_idx;

  function automatic logic [4:0] sym_of(input logic [3:0] n);
    case (n)
      4'h0: return 5'h1E; 4'h1: return 5'h09; 4'h2: return 5'h14; 4'h3: return 5'h15;
      4'h4: return 5'h0A; 4'h5: return 5'h0B; 4'h6: return 5'h0E; 4'h7: return 5'h0F;
      4'h8: return 5'h12; 4'h9: return 5'h13; 4'hA: return 5'h16; 4'hB: return 5'h17;
      4'hC: return 5'h1A; 4'hD: return 5'h1B; 4'hE: return 5'h1C; default: return 5'h1D;
    endcase
  endfunction

  function automatic logic [9:0] word_of(input logic [7:0] b);
    return {sym_of(b[7:4]), sym_of(b[3:0])};
  endfunction

  function automatic logic [7:0] dir_byte(input int k);
    case (k % 8)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'h5A; 3: return 8'hA5;
      4: return 8'h0F; 5: return 8'hF0; 6: return 8'h3C; default: return 8'hC3;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  task automatic step();
    if (!started) begin
      tx_strobe = 1'b0;
      if (tx_ready) begin
        started = 1; mc = 9; mw = '0; mhv = 0; mhb = '0;
        exp_line = 1'b0; mkind = 0; prev_kind = 0;
      end else begin
        check(line_out == 1'b0, "R1 line low before start", int'(line_out), 0);
        wait_cyc++;
        if (wait_cyc == 8) check(1'b0, "R1 ready never rose after reset", 0, 1);
      end
    end
    if (started) begin
      check(tx_ready == (mc == 9), "R2 ready cadence", int'(tx_ready), int'(mc == 9));
      case (prev_kind)
        0: check(line_out == exp_line, "R1 R6 line after reset", int'(line_out), int'(exp_line));
        1: check(line_out == exp_line, "R7 R6 sync word on line", int'(line_out), int'(exp_line));
        default: check(line_out == exp_line, "R3 R4 R5 R6 R8 data word on line",
                       int'(line_out), int'(exp_line));
      endcase
      // stimulus for the coming edge
      case (mode)
        0: begin tx_strobe = 1'b0; tx_data = 8'($urandom); end
        1: begin
             tx_strobe = 1'b1;
             if (mc == 9) begin tx_data = dir_byte(dir_idx); dir_idx++; end
             else tx_data = 8'($urandom);
           end
        default: begin tx_strobe = 1'($urandom % 2); tx_data = 8'($urandom); end
      endcase
      // model the edge
      exp_line = exp_line ^ mw[9];
      prev_kind = mkind;
      if (mc == 9) begin
        if (mhv) begin mw = word_of(mhb); mkind = 2; end
        else     begin mw = 10'b11000_10001; mkind = 1; end
        mhv = tx_strobe;
        if (tx_strobe) mhb = tx_data;
        mc = 0;
      end else begin
        mw = {mw[8:0], 1'b0};
        mc++;
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    started = 0; wait_cyc = 0; mode = 0; dir_idx = 0;
    repeat (3) begin
      @(negedge clk);
      check(line_out == 1'b0, "R1 line in reset", int'(line_out), 0);
      check(tx_ready == 1'b0, "R1 ready in reset", int'(tx_ready), 0);
    end
    rst_n = 1'b1;
    // idle: sync only
    for (int i = 0; i < 200; i++) begin @(negedge clk); step(); end
    // directed corner bytes, back to back
    mode = 1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); step(); end
    // random strobes, data changing every cycle
    mode = 2;
    for (int i = 0; i < 1500; i++) begin @(negedge clk); step(); end
    // asynchronous reset in mid-word
    @(negedge clk);
    #3 rst_n = 1'b0;
    tx_strobe = 1'b1;
    #2;
    check(line_out == 1'b0, "R1 line cleared by async reset", int'(line_out), 0);
    check(tx_ready == 1'b0, "R1 ready cleared by async reset", int'(tx_ready), 0);
    repeat (2) begin
      @(negedge clk);
      check(line_out == 1'b0, "R1 line held in reset", int'(line_out), 0);
    end
    rst_n = 1'b1;
    started = 0; wait_cyc = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); step(); end
    mode = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); step(); end
    summary();
    $finish;
  end
endmodule